// File: doc/BRIEF.md
# 4:2:2 Video Byte-Stream Formatter

The formatter takes one full-resolution YCbCr pixel (luma plus both chroma components) per pixel period. It turns the pixels into a chroma-subsampled 4:2:2 stream. In narrow mode the block runs on a clock at twice the pixel rate. A strobe marks every second cycle as a new-pixel cycle. One component leaves per clock on the low lane, in the co-sited order blue-difference, luma, red-difference, luma. In wide mode the strobe fires every clock. Both lanes then carry data: luma on the upper lane, and alternating chroma on the lower lane.

The timing generator supplies an active flag with each pixel. Pixels that arrive with the flag low are replaced by fixed blanking levels. Every emitted code is clamped out of the ranges that embedded sync words use. No timing reference words are ever inserted. A delayed copy of the active flag travels alongside the data, so downstream logic can frame each run.

The component width is a parameter. At 8 bits the blanking levels are 10h and 80h. At 10 bits they are 040h and 200h.

Top module: `yc422_formatter`

## Requirements
- R1: In narrow mode (wide_i=0) each pixel pair P0,P1 of an active run leaves on data_o[W-1:0] as Cb(P0), Y(P0), Cr(P0), Y(P1), one component per clock. The chroma of P1 is discarded.
- R2: A pixel strobed with active_i=0 restarts the pairing, so the first component of every active run is the Cb of its first pixel. In narrow mode active_o changes only on the clock that presents a chroma slot.
- R3: While active_o is 0, luma slots carry 16<<(W-8) and chroma slots carry 128<<(W-8). That is 10h/80h for W=8 and 040h/200h for W=10.
- R4: Every code on both lanes lies in [2^(W-8), 2^W-1-2^(W-8)]. That is 01h..FEh for W=8 and 004h..3FBh for W=10. Values outside this range are clamped to the nearest limit.
- R5: In wide mode (wide_i=1), data_o = {Y, C}, where Y is the upper lane and C the lower lane. C alternates Cb(P0), Cr(P0) across each pixel pair, starting with Cb. The output changes only on clocks that follow a strobe.
- R6: The first output slot of a pixel strobed in cycle k is presented in cycle k+2. In narrow mode its luma follows in cycle k+3. active_o carries the pixel's active flag with the same delay.
- R7: In narrow mode the upper lane holds the luma blanking level.
- R8: During reset, data_o = {Y blank, C blank} and active_o = 0.
- R9: A run of N active pixels yields exactly 2N active output slots in narrow mode. No extra words are added before, inside or after the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock: twice the pixel rate in narrow mode, the pixel rate in wide mode |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | 1 selects the two-lane output, 0 selects the single-lane stream |
| stb_i | input | 1 | Marks a cycle carrying a new pixel |
| active_i | input | 1 | Active-video flag for the strobed pixel |
| pix_i | input | 3*COMP_W | Pixel as {Y, Cb, Cr} |
| data_o | output | 2*COMP_W | {upper lane, lower lane}; the narrow stream is on the lower lane |
| active_o | output | 1 | Active flag aligned with data_o |

## Verification
The bench builds two instances: one with COMP_W=8, and a second with COMP_W=10. The 8-bit instance walks a table of three runs of 8, 3 and 2 pixels, seeded with 00h and FFh codes. This covers the odd-length run, the restart of the pairing and both clamp limits. It then covers wide mode and strobe holding. The 10-bit instance exercises the scaled limits 004h and 3FBh and the scaled blanking levels, which an 8-bit build cannot reach.

// File: rtl/yc_fmt_pkg.sv
package yc_fmt_pkg;
  typedef enum logic {SLOT_CHROMA = 1'b0, SLOT_LUMA = 1'b1} slot_e;

  function automatic int unsigned clamp_lo(int unsigned w);
    return 1 << (w - 8);
  endfunction

  function automatic int unsigned clamp_hi(int unsigned w);
    return (1 << w) - 1 - (1 << (w - 8));
  endfunction
endpackage

// File: rtl/yc_pixel_stage.sv
module yc_pixel_stage #(
  parameter int unsigned W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           stb_i,
  input  logic           active_i,
  input  logic [3*W-1:0] pix_i,
  output logic [W-1:0]   y_o,
  output logic [W-1:0]   c_o,
  output logic           act_o
);
  logic [W-1:0] cb, cr, y, cr_hold_q;
  logic         pair_odd_q;

  assign {y, cb, cr} = pix_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o        <= '0;
      c_o        <= '0;
      act_o      <= 1'b0;
      pair_odd_q <= 1'b0;
      cr_hold_q  <= '0;
    end else if (stb_i) begin
      act_o      <= active_i;
      y_o        <= y;
      pair_odd_q <= active_i ? ~pair_odd_q : 1'b0;
      // even pixel supplies both chroma; odd pixel reuses the held Cr
      if (!pair_odd_q || !active_i) begin
        c_o       <= cb;
        cr_hold_q <= cr;
      end else begin
        c_o <= cr_hold_q;
      end
    end
  end
endmodule

// File: rtl/yc_clamp.sv
module yc_clamp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] val_o
);
  import yc_fmt_pkg::*;
  localparam logic [W-1:0] LO = W'(clamp_lo(W));
  localparam logic [W-1:0] HI = W'(clamp_hi(W));

  always_comb begin
    if (val_i < LO)      val_o = LO;
    else if (val_i > HI) val_o = HI;
    else                 val_o = val_i;
  end
endmodule

// File: rtl/yc_out_reg.sv
module yc_out_reg #(
  parameter int unsigned W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           stb_i,
  input  logic           wide_i,
  input  logic           act_i,
  input  logic [W-1:0]   y_i,
  input  logic [W-1:0]   c_i,
  output logic [2*W-1:0] data_o,
  output logic           active_o
);
  import yc_fmt_pkg::*;
  localparam logic [W-1:0] Y_BLK = W'(16 << (W - 8));
  localparam logic [W-1:0] C_BLK = W'(128 << (W - 8));

  slot_e slot;
  assign slot = stb_i ? SLOT_LUMA : SLOT_CHROMA;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o   <= {Y_BLK, C_BLK};
      active_o <= 1'b0;
    end else if (wide_i) begin
      if (stb_i) begin
        active_o <= act_i;
        data_o   <= act_i ? {y_i, c_i} : {Y_BLK, C_BLK};
      end
    end else begin
      active_o          <= act_i;
      data_o[2*W-1:W]   <= Y_BLK;
      if (slot == SLOT_LUMA) data_o[W-1:0] <= act_i ? y_i : Y_BLK;
      else                   data_o[W-1:0] <= act_i ? c_i : C_BLK;
    end
  end
endmodule

// File: rtl/yc422_formatter.sv
module yc422_formatter #(
  parameter int unsigned COMP_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wide_i,
  input  logic                stb_i,
  input  logic                active_i,
  input  logic [3*COMP_W-1:0] pix_i,
  output logic [2*COMP_W-1:0] data_o,
  output logic                active_o
);
  localparam int unsigned NCOMP = 2;

  logic [COMP_W-1:0] raw [NCOMP];
  logic [COMP_W-1:0] lim [NCOMP];
  logic              act_s;

  yc_pixel_stage #(.W(COMP_W)) stage_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (stb_i),
    .active_i (active_i),
    .pix_i    (pix_i),
    .y_o      (raw[0]),
    .c_o      (raw[1]),
    .act_o    (act_s)
  );

  for (genvar g = 0; g < NCOMP; g++) begin : g_clamp
    yc_clamp #(.W(COMP_W)) clamp_i (.val_i(raw[g]), .val_o(lim[g]));
  end

  yc_out_reg #(.W(COMP_W)) out_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (stb_i),
    .wide_i   (wide_i),
    .act_i    (act_s),
    .y_i      (lim[0]),
    .c_i      (lim[1]),
    .data_o   (data_o),
    .active_o (active_o)
  );
endmodule

// File: rtl/yc422_formatter_checker.sv
module yc422_formatter_checker #(
  parameter int unsigned W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           wide_i,
  input logic           stb_i,
  input logic [2*W-1:0] data_o,
  input logic           active_o
);
  import yc_fmt_pkg::*;
  localparam logic [W-1:0] LO    = W'(clamp_lo(W));
  localparam logic [W-1:0] HI    = W'(clamp_hi(W));
  localparam logic [W-1:0] Y_BLK = W'(16 << (W - 8));
  localparam logic [W-1:0] C_BLK = W'(128 << (W - 8));

  logic [W-1:0] lo_lane, up_lane;
  assign lo_lane = data_o[W-1:0];
  assign up_lane = data_o[2*W-1:W];

  assert_no_reserved_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_lane >= LO) && (lo_lane <= HI) && (up_lane >= LO) && (up_lane <= HI));

  assert_blank_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (lo_lane == Y_BLK || lo_lane == C_BLK));

  assert_run_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_i && stb_i) |=> $stable(active_o));

  assert_wide_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_i && !stb_i) |=> $stable(data_o));

  assert_upper_lane_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_i && $past(!wide_i)) |-> (up_lane == Y_BLK));
endmodule

bind yc422_formatter yc422_formatter_checker #(.W(COMP_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wide_i   (wide_i),
  .stb_i    (stb_i),
  .data_o   (data_o),
  .active_o (active_o)
);

// File: tb/yc422_formatter_tb_top.sv
module yc422_formatter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        wide8 = 1'b0, stb8 = 1'b0, act8 = 1'b0;
  logic [23:0] pix8 = '0;
  logic [15:0] d8;
  logic        a8o;
  logic        stb10 = 1'b0, act10 = 1'b0;
  logic [29:0] pix10 = '0;
  logic [19:0] d10;
  logic        a10o;

  yc422_formatter #(.COMP_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wide_i(wide8), .stb_i(stb8),
    .active_i(act8), .pix_i(pix8), .data_o(d8), .active_o(a8o));

  yc422_formatter #(.COMP_W(10)) dut_w_i (
    .clk_i(clk), .rst_ni(rst_n), .wide_i(1'b0), .stb_i(stb10),
    .active_i(act10), .pix_i(pix10), .data_o(d10), .active_o(a10o));

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] log8  [512];
  logic        loga8 [512];
  logic [19:0] log10 [512];
  logic        loga10[512];

  // {active, Y, Cb, Cr}
  localparam logic [24:0] VEC [22] = '{
    {1'b0,24'hFF00FF}, {1'b0,24'hFF00FF},
    {1'b1,24'h203040}, {1'b1,24'h21AABB}, {1'b1,24'hFF0050}, {1'b1,24'h00CCDD},
    {1'b1,24'h80FF01}, {1'b1,24'h7F1122}, {1'b1,24'h1045FE}, {1'b1,24'hEB0000},
    {1'b0,24'hFF00FF}, {1'b0,24'hFF00FF},
    {1'b1,24'h506070}, {1'b1,24'h516171}, {1'b1,24'h526272},
    {1'b0,24'hFF00FF}, {1'b0,24'hFF00FF},
    {1'b1,24'h90A0B0}, {1'b1,24'h91A1B1},
    {1'b0,24'hFF00FF}, {1'b0,24'hFF00FF}, {1'b0,24'hFF00FF}};
  localparam logic [7:0] EXP [26] = '{
    8'h30,8'h20,8'h40,8'h21, 8'h01,8'hFE,8'h50,8'h01,
    8'hFE,8'h80,8'h01,8'h7F, 8'h45,8'h10,8'hFE,8'hEB,
    8'h60,8'h50,8'h70,8'h51,8'h62,8'h52, 8'hA0,8'h90,8'hB0,8'h91};

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic s8, input logic a, input logic [23:0] p,
                      input logic s10, input logic a10, input logic [29:0] p10);
    @(negedge clk);
    log8[cyc] = d8;   loga8[cyc] = a8o;
    log10[cyc] = d10; loga10[cyc] = a10o;
    stb8 = s8; act8 = a; pix8 = p;
    stb10 = s10; act10 = a10; pix10 = p10;
    cyc++;
  endtask

  initial begin
    #(100000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base, n, rises;
    logic [15:0] upbad;
    repeat (3) @(negedge clk);
    // R8 reset values
    chk(d8 == 16'h1080 && !a8o, "R8 reset 8b", d8, 16'h1080);
    chk(d10 == {10'h040, 10'h200} && !a10o, "R8 reset 10b", d10, {10'h040, 10'h200});
    rst_n = 1'b1;
    repeat (4) step(0, 0, '0, 0, 0, '0);

    // table walk, narrow mode
    base = cyc;
    foreach (VEC[i]) begin
      step(1, VEC[i][24], VEC[i][23:0], 0, 0, '0);
      step(0, VEC[i][24], VEC[i][23:0], 0, 0, '0);
    end
    repeat (4) step(0, 0, '0, 0, 0, '0);
    n = 0; rises = 0; upbad = '0;
    for (int k = base; k < cyc; k++) begin
      if (log8[k][15:8] != 8'h10) upbad = log8[k];
      if (loga8[k] && !loga8[k-1]) rises++;
      if (loga8[k]) begin
        if (n < 26) chk(log8[k][7:0] == EXP[n], "R1 R2 R4 stream", log8[k][7:0], EXP[n]);
        n++;
      end
    end
    chk(n == 26, "R9 active slot count", n, 26);
    chk(rises == 3, "R9 run count", rises, 3);
    chk(upbad == '0, "R7 upper lane", upbad, 16'h1000);
    chk(!loga8[base+5] && loga8[base+6], "R6 latency", {loga8[base+5], loga8[base+6]}, 2'b01);
    chk(log8[base+4][7:0] == 8'h80, "R3 chroma blank", log8[base+4][7:0], 8'h80);
    chk(log8[base+5][7:0] == 8'h10, "R3 luma blank", log8[base+5][7:0], 8'h10);
    chk(log8[base+22][7:0] == 8'h80 && !loga8[base+22], "R3 blank after run",
        log8[base+22][7:0], 8'h80);

    // wide mode
    wide8 = 1'b1;
    base = cyc;
    step(1, 0, 24'hFF00FF, 0, 0, '0);
    step(1, 0, 24'hFF00FF, 0, 0, '0);
    step(1, 1, 24'h354555, 0, 0, '0);
    step(1, 1, 24'h364656, 0, 0, '0);
    step(1, 1, 24'h374757, 0, 0, '0);
    step(1, 1, 24'h384858, 0, 0, '0);
    repeat (3) step(1, 0, 24'hFF00FF, 0, 0, '0);
    chk(log8[base+4] == 16'h3545 && loga8[base+4], "R5 R6 wide Cb", log8[base+4], 16'h3545);
    chk(log8[base+5] == 16'h3655, "R5 wide Cr", log8[base+5], 16'h3655);
    chk(log8[base+6] == 16'h3747, "R5 wide Cb2", log8[base+6], 16'h3747);
    chk(log8[base+7] == 16'h3857, "R5 wide Cr2", log8[base+7], 16'h3857);
    chk(log8[base+8] == 16'h1080 && !loga8[base+8], "R3 wide blank", log8[base+8], 16'h1080);
    // strobe hold
    base = cyc;
    step(1, 1, 24'h607080, 0, 0, '0);
    step(0, 1, 24'h112233, 0, 0, '0);
    step(0, 1, 24'h445566, 0, 0, '0);
    step(0, 1, 24'h778899, 0, 0, '0);
    step(1, 0, 24'hFF00FF, 0, 0, '0);
    step(1, 0, 24'hFF00FF, 0, 0, '0);
    chk(log8[base+4] == 16'h1080 && !loga8[base+4], "R5 hold without strobe", log8[base+4], 16'h1080);
    chk(log8[base+5] == 16'h6070 && loga8[base+5], "R5 load on strobe", log8[base+5], 16'h6070);

    // 10-bit instance, narrow mode
    base = cyc;
    for (int e = 0; e < 6; e++) begin
      logic a; logic [29:0] p;
      a = (e == 2 || e == 3);
      p = (e == 2) ? {10'h3FF, 10'h000, 10'h002} :
          (e == 3) ? {10'h3FC, 10'h3FD, 10'h100} : {10'h3FF, 10'h000, 10'h3FF};
      step(1, 0, '0, 1, a, p);
      step(0, 0, '0, 0, a, p);
    end
    repeat (2) step(0, 0, '0, 0, 0, '0);
    chk(log10[base+4][9:0] == 10'h200, "R3 10b chroma blank", log10[base+4][9:0], 10'h200);
    chk(log10[base+5][9:0] == 10'h040, "R3 10b luma blank", log10[base+5][9:0], 10'h040);
    chk(log10[base+6][9:0] == 10'h004 && loga10[base+6], "R4 10b Cb low", log10[base+6][9:0], 10'h004);
    chk(log10[base+7][9:0] == 10'h3FB, "R4 10b Y high", log10[base+7][9:0], 10'h3FB);
    chk(log10[base+8][9:0] == 10'h004, "R4 10b Cr low", log10[base+8][9:0], 10'h004);
    chk(log10[base+9][9:0] == 10'h3FB, "R1 R4 10b Y1", log10[base+9][9:0], 10'h3FB);
    chk(log10[base+10][9:0] == 10'h200 && !loga10[base+10], "R3 10b blank after",
        log10[base+10][9:0], 10'h200);
    chk(log10[base+7][19:10] == 10'h040, "R7 10b upper lane", log10[base+7][19:10], 10'h040);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule